// File: doc/BRIEF.md
# External Bus Access Cycle Sequencer

The sequencer produces the state-by-state timing of a single access to the external address space of a microcontroller bus. A request names one of three target areas, the address, the direction and the transfer size. The block looks up the shape of the cycle from static configuration inputs:
- whether the bus is 8 or 16 bits wide,
- whether the access takes 2 or 3 bus states,
- how many program wait states are inserted.

It then drives the address, the strobes and the write data for one clock per bus state, and reports completion with a one-clock pulse. A 16-bit transfer to an area configured 8 bits wide runs as two byte cycles. Each of the two byte cycles has the full length.

The areas are the basic area, expansion area A and expansion area B. Expansion area A allows 0 to 3 program waits and is forced to a 16-bit bus while memory-card mode is on. Expansion area B allows up to 10 program waits, coded non-linearly.

The controller is a five-state machine:
- `S_IDLE` waits for a request and leaves for `S_T1` when one is present.
- `S_T1`, the first bus state, always moves to `S_T2`.
- From `S_T2`, a 2-state cycle ends the byte cycle. A 3-state cycle goes to `S_TW` when waits remain and otherwise to `S_T3`.
- `S_TW` repeats once per program wait and moves to `S_T3` in the clock that holds the last wait.
- `S_T3` ends the byte cycle.
- The end of a byte cycle returns to `S_T1` when the second byte of a split transfer is still pending. Otherwise it returns to `S_IDLE`.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset, req_ready is 1, bus_as_n, bus_rd_n and bus_wr_n are 1, done is 0 and rd_data is 0.
- R2: When the target area is set to 2-state access (long bit 0), every byte cycle lasts exactly 2 clocks and no program wait is inserted, whatever the wait code.
- R3: The basic area, area code 0 (and the spare code 3, which acts as the basic area), runs 3-state cycles with no program waits when its long bit is 1.
- R4: Expansion area A, area code 1, with cfg_exp_cs_en=1 and cfg_exp_long=1, inserts cfg_wait_code[1:0] waits (0 to 3). Bit 2 of the code is ignored, giving a cycle of 3 + waits clocks.
- R5: Expansion area B, area code 2, with cfg_exp_cs_en=1 and cfg_exp_long=1, inserts the following waits:
  - codes 0, 1, 2 and 3 insert 0, 1, 2 and 3 waits;
  - codes 4, 5, 6 and 7 insert 4, 6, 8 and 10 waits.
- R6: With cfg_exp_cs_en=0, a 3-state expansion access inserts no waits for any wait code.
- R7: bus_wide is 1 during every bus state of an access to a 16-bit area. The basic area follows cfg_basic_wide and both expansion areas follow cfg_exp_wide. With cfg_card_mode=1, expansion area A is 16-bit regardless of cfg_exp_wide; the other areas are unaffected.
- R8: A word access (req_word=1) to an 8-bit area runs as two full-length byte cycles, and all data travels on lane [7:0].
  - The first cycle uses the even address (bit 0 cleared) and carries the upper data byte.
  - The second cycle uses the odd address and carries the lower byte.
  - The read result is {first byte, second byte}.
- R9: A word access to a 16-bit area is one cycle at the even address using all 16 data bits. A byte access (req_word=0) is one cycle at the exact address on lane [7:0], and rd_data[15:8] reads as 0.
- R10: bus_as_n is 0 in every bus state. bus_rd_n is 0 in every state of a read. bus_wr_n is 0 from the second state through the last state of a write. bus_rd_n and bus_wr_n are never both 0.
- R11: Acceptance, completion and configuration sampling work as follows:
  - A request is taken only while req_ready is 1 (idle); req_valid during a busy access is ignored.
  - done is 1 for exactly one clock, in the clock after the last bus state, with rd_data valid from then on.
  - The configuration is sampled at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_basic_wide | input | 1 | Basic area bus is 16 bits when 1 |
| cfg_basic_long | input | 1 | Basic area uses 3-state cycles when 1 |
| cfg_exp_wide | input | 1 | Expansion areas use a 16-bit bus when 1 |
| cfg_exp_long | input | 1 | Expansion areas use 3-state cycles when 1 |
| cfg_exp_cs_en | input | 1 | Expansion select enabled; gates program waits |
| cfg_wait_code | input | 3 | Program wait code for the expansion areas |
| cfg_card_mode | input | 1 | Memory-card mode; forces expansion area A to 16 bits |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_area | input | 2 | Target area: 0 basic, 1 expansion A, 2 expansion B, 3 spare (basic) |
| req_addr | input | AW | Access address |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 for a 16-bit transfer, 0 for a byte |
| req_wdata | input | DW | Write data |
| rd_data | output | DW | Assembled read data |
| done | output | 1 | One-clock completion pulse |
| bus_addr | output | AW | Address of the current bus state |
| bus_as_n | output | 1 | Active-low address strobe |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_wide | output | 1 | Current cycle uses the 16-bit bus |
| bus_dout | output | DW | Write data driven on the bus |
| bus_din | input | DW | Read data from the bus |

## Verification
Each area is swept over every combination of width, state count and wait code, so that wrong lengths show up:
- a wait code applied on the basic area or in a 2-state cycle,
- bit 2 of the code leaking into expansion area A,
- a linear mapping used for expansion area B.

Word reads on narrow areas separate the even/odd byte order and the result packing from the wide single-cycle case. Byte accesses at odd addresses show that the exact address and the low lane are used. Separate runs cover several cases:
- a cleared expansion enable;
- memory-card mode on each area, showing that only expansion area A is widened;
- configuration changed and req_valid pulsed in the middle of an access, to prove sampling at acceptance and that requests are ignored while busy.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;

    localparam int WAIT_W   = 4;
    localparam int MAX_WAIT = 10;

    typedef enum logic [1:0] {
        AR_BASIC = 2'd0,
        AR_EXPA  = 2'd1,
        AR_EXPB  = 2'd2,
        AR_SPARE = 2'd3
    } area_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_T1,
        S_T2,
        S_TW,
        S_T3
    } seq_state_t;

    typedef struct packed {
        logic              wide;
        logic              long3;
        logic [WAIT_W-1:0] waits;
    } acc_shape_t;

endpackage

// File: rtl/ext_bus_shape.sv
module ext_bus_shape
    import ext_bus_pkg::*;
(
    input  area_t      area,
    input  logic       cfg_basic_wide,
    input  logic       cfg_basic_long,
    input  logic       cfg_exp_wide,
    input  logic       cfg_exp_long,
    input  logic       cfg_exp_cs_en,
    input  logic [2:0] cfg_wait_code,
    input  logic       cfg_card_mode,
    output acc_shape_t shape
);

    logic waits_on;

    assign waits_on = cfg_exp_cs_en && cfg_exp_long;

    always_comb begin
        shape = '0;
        unique case (area)
            AR_EXPA: begin
                shape.wide  = cfg_exp_wide || cfg_card_mode;
                shape.long3 = cfg_exp_long;
                shape.waits = waits_on ? {2'b00, cfg_wait_code[1:0]} : '0;
            end
            AR_EXPB: begin
                shape.wide  = cfg_exp_wide;
                shape.long3 = cfg_exp_long;
                if (!waits_on)
                    shape.waits = '0;
                else if (cfg_wait_code[2])
                    shape.waits = {1'b0, cfg_wait_code[1:0], 1'b0} + 4'd4;
                else
                    shape.waits = {1'b0, cfg_wait_code};
            end
            default: begin
                shape.wide  = cfg_basic_wide;
                shape.long3 = cfg_basic_long;
                shape.waits = '0;
            end
        endcase
    end

endmodule

// File: rtl/ext_bus_wait_ctr.sv
module ext_bus_wait_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec)
            cnt <= cnt - 1'b1;
    end

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt != '0));

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ext_bus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_basic_wide,
    input  logic          cfg_basic_long,
    input  logic          cfg_exp_wide,
    input  logic          cfg_exp_long,
    input  logic          cfg_exp_cs_en,
    input  logic [2:0]    cfg_wait_code,
    input  logic          cfg_card_mode,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_area,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic          req_word,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic [AW-1:0] bus_addr,
    output logic          bus_as_n,
    output logic          bus_rd_n,
    output logic          bus_wr_n,
    output logic          bus_wide,
    output logic [DW-1:0] bus_dout,
    input  logic [DW-1:0] bus_din
);

    localparam int BW = DW / 2;
    localparam logic [WAIT_W-1:0] WAIT_CAP = WAIT_W'(MAX_WAIT);

    seq_state_t        state_q, state_d;
    acc_shape_t        shape_in, shape_q;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q, rd_q;
    logic              write_q, word_q, second_q, done_q;
    logic              split_q, more, end_byte, accept, active;
    logic [WAIT_W-1:0] wcnt, tw_run;
    logic [AW-1:0]     cyc_addr;
    logic [DW-1:0]     lane;

    ext_bus_shape u_shape (
        .area           (area_t'(req_area)),
        .cfg_basic_wide (cfg_basic_wide),
        .cfg_basic_long (cfg_basic_long),
        .cfg_exp_wide   (cfg_exp_wide),
        .cfg_exp_long   (cfg_exp_long),
        .cfg_exp_cs_en  (cfg_exp_cs_en),
        .cfg_wait_code  (cfg_wait_code),
        .cfg_card_mode  (cfg_card_mode),
        .shape          (shape_in)
    );

    ext_bus_wait_ctr #(.W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == S_T1),
        .load_val (shape_q.waits),
        .dec      (state_q == S_TW),
        .cnt      (wcnt)
    );

    assign accept   = (state_q == S_IDLE) && req_valid;
    assign split_q  = word_q && !shape_q.wide;
    assign more     = split_q && !second_q;
    assign end_byte = ((state_q == S_T2) && !shape_q.long3) || (state_q == S_T3);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_valid) state_d = S_T1;
            S_T1:   state_d = S_T2;
            S_T2: begin
                if (!shape_q.long3)
                    state_d = more ? S_T1 : S_IDLE;
                else if (wcnt != '0)
                    state_d = S_TW;
                else
                    state_d = S_T3;
            end
            S_TW:   if (wcnt == WAIT_W'(1)) state_d = S_T3;
            S_T3:   state_d = more ? S_T1 : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // request capture, byte phase, completion and read assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shape_q  <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            write_q  <= 1'b0;
            word_q   <= 1'b0;
            second_q <= 1'b0;
            done_q   <= 1'b0;
            rd_q     <= '0;
            tw_run   <= '0;
        end else begin
            done_q <= end_byte && !more;
            tw_run <= (state_q == S_TW) ? tw_run + 1'b1 : '0;
            if (accept) begin
                shape_q  <= shape_in;
                addr_q   <= req_addr;
                wdata_q  <= req_wdata;
                write_q  <= req_write;
                word_q   <= req_word;
                second_q <= 1'b0;
            end
            if (end_byte && more)
                second_q <= 1'b1;
            if (end_byte && !write_q) begin
                if (!word_q)
                    rd_q <= {{BW{1'b0}}, bus_din[BW-1:0]};
                else if (shape_q.wide)
                    rd_q <= bus_din;
                else if (!second_q)
                    rd_q <= {bus_din[BW-1:0], {BW{1'b0}}};
                else
                    rd_q[BW-1:0] <= bus_din[BW-1:0];
            end
        end
    end

    // outputs
    always_comb begin
        active   = (state_q != S_IDLE);
        cyc_addr = word_q ? {addr_q[AW-1:1], second_q} : addr_q;
        if (!word_q)
            lane = {{BW{1'b0}}, wdata_q[BW-1:0]};
        else if (shape_q.wide)
            lane = wdata_q;
        else if (second_q)
            lane = {{BW{1'b0}}, wdata_q[BW-1:0]};
        else
            lane = {{BW{1'b0}}, wdata_q[DW-1:BW]};
        req_ready = (state_q == S_IDLE);
        bus_as_n  = !active;
        bus_rd_n  = !(active && !write_q);
        bus_wr_n  = !(active && write_q && (state_q != S_T1));
        bus_wide  = active && shape_q.wide;
        bus_addr  = active ? cyc_addr : '0;
        bus_dout  = (active && write_q) ? lane : '0;
        done      = done_q;
        rd_data   = rd_q;
    end

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    // R11
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> (!bus_as_n && bus_addr == $past(req_word ?
            {req_addr[AW-1:1], 1'b0} : req_addr)));

    // R2
    short_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TW) |-> shape_q.long3);

    // R5
    wait_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tw_run <= WAIT_CAP);

    // R8
    lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && split_q) |-> (bus_addr[0] == second_q));

endmodule

// File: tb/ext_bus_seq_bench.sv
`timescale 1ns/1ps
module ext_bus_seq_bench;

    typedef struct packed {
        logic        as_n;
        logic        rd_n;
        logic        wr_n;
        logic        wide;
        logic [15:0] addr;
        logic [15:0] dout;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_basic_wide = 0, cfg_basic_long = 0, cfg_exp_wide = 0, cfg_exp_long = 0;
    logic        cfg_exp_cs_en = 0, cfg_card_mode = 0;
    logic [2:0]  cfg_wait_code = 0;
    logic        req_valid = 0, req_write = 0, req_word = 0;
    logic [1:0]  req_area = 0;
    logic [15:0] req_addr = 0, req_wdata = 0;
    logic        req_ready, done, bus_as_n, bus_rd_n, bus_wr_n, bus_wide;
    logic [15:0] rd_data, bus_addr, bus_dout, bus_din;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    assign bus_din = {~bus_addr[7:0], bus_addr[7:0] ^ 8'h5A};

    ext_bus_seq u_ext_bus_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_basic_wide(cfg_basic_wide), .cfg_basic_long(cfg_basic_long),
        .cfg_exp_wide(cfg_exp_wide), .cfg_exp_long(cfg_exp_long),
        .cfg_exp_cs_en(cfg_exp_cs_en), .cfg_wait_code(cfg_wait_code),
        .cfg_card_mode(cfg_card_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_area(req_area),
        .req_addr(req_addr), .req_write(req_write), .req_word(req_word),
        .req_wdata(req_wdata), .rd_data(rd_data), .done(done),
        .bus_addr(bus_addr), .bus_as_n(bus_as_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_wide(bus_wide), .bus_dout(bus_dout),
        .bus_din(bus_din)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural model of the cycle shape
    function automatic int m_waits(int area);
        int c = int'(cfg_wait_code);
        if ((area == 1 || area == 2) && cfg_exp_cs_en && cfg_exp_long) begin
            if (area == 1) return c % 4;
            return (c < 4) ? c : (c * 2 - 4);
        end
        return 0;
    endfunction

    function automatic bit m_wide(int area);
        if (area == 1) return cfg_exp_wide | cfg_card_mode;
        if (area == 2) return cfg_exp_wide;
        return cfg_basic_wide;
    endfunction

    function automatic bit m_long(int area);
        return (area == 1 || area == 2) ? cfg_exp_long : cfg_basic_long;
    endfunction

    task automatic run_access(int area, logic [15:0] addr, bit wr, bit word,
                              logic [15:0] wd, string tag, bit poke, bit twiddle);
        exp_t q[$];
        bit   wide = m_wide(area);
        bit   lng  = m_long(area);
        int   nst  = lng ? 3 + m_waits(area) : 2;
        int   nby  = (word && !wide) ? 2 : 1;
        logic [15:0] ev = {addr[15:1], 1'b0};
        logic [15:0] exprd;
        string dtag = (word && !wide) ? "R8" : "R9";
        logic [8:0] saved = {cfg_basic_wide, cfg_basic_long, cfg_exp_wide, cfg_exp_long,
                             cfg_exp_cs_en, cfg_card_mode, cfg_wait_code};
        int n;
        for (int b = 0; b < nby; b++) begin
            logic [15:0] a = word ? (ev | 16'(b)) : addr;
            logic [15:0] d;
            if (!wr) d = 16'h0;
            else if (!word) d = {8'h00, wd[7:0]};
            else if (wide) d = wd;
            else d = (b == 0) ? {8'h00, wd[15:8]} : {8'h00, wd[7:0]};
            for (int s = 0; s < nst; s++)
                q.push_back('{1'b0, wr, !(wr && s > 0), wide, a, d});
        end
        if (!word) exprd = {8'h00, addr[7:0] ^ 8'h5A};
        else if (wide) exprd = {~ev[7:0], ev[7:0] ^ 8'h5A};
        else exprd = {ev[7:0] ^ 8'h5A, (ev[7:0] | 8'h01) ^ 8'h5A};

        req_area = 2'(area); req_addr = addr; req_write = wr; req_word = word;
        req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < q.size(); i++) begin
            if (i > 0) @(negedge clk);
            if (twiddle && i == 0) begin
                {cfg_basic_wide, cfg_basic_long, cfg_exp_wide, cfg_exp_long,
                 cfg_exp_cs_en, cfg_card_mode, cfg_wait_code} = ~saved;
            end
            if (poke && i == 1) begin req_valid = 1'b1; req_addr = ~addr; end
            if (poke && i == 2) req_valid = 1'b0;
            chk("R10", "as_n", bus_as_n, q[i].as_n);
            chk("R10", "rd_n", bus_rd_n, q[i].rd_n);
            chk("R10", "wr_n", bus_wr_n, q[i].wr_n);
            chk("R7", "bus_wide", bus_wide, q[i].wide);
            chk(dtag, "bus_addr", bus_addr, q[i].addr);
            chk(dtag, "bus_dout", bus_dout, q[i].dout);
            chk("R11", "busy ready", req_ready, 1'b0);
            chk("R11", "early done", done, 1'b0);
        end
        req_valid = 1'b0;
        @(negedge clk);
        n = 0;
        while (done !== 1'b1 && n < 40) begin n++; @(negedge clk); end
        chk(tag, "extra states", n, 0);
        chk("R11", "done", done, 1'b1);
        chk("R11", "idle ready", req_ready, 1'b1);
        chk("R10", "idle as_n", bus_as_n, 1'b1);
        if (!wr) chk(dtag, "rd_data", rd_data, exprd);
        @(negedge clk);
        chk("R11", "done drop", done, 1'b0);
        chk("R11", "no extra accept", bus_as_n, 1'b1);
        if (twiddle)
            {cfg_basic_wide, cfg_basic_long, cfg_exp_wide, cfg_exp_long,
             cfg_exp_cs_en, cfg_card_mode, cfg_wait_code} = saved;
    endtask

    function automatic string tag_for(int area, bit lng);
        if (!lng) return "R2";
        if (area == 1) return "R4";
        if (area == 2) return "R5";
        return "R3";
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "ready", req_ready, 1'b1);
        chk("R1", "as_n", bus_as_n, 1'b1);
        chk("R1", "rd_n", bus_rd_n, 1'b1);
        chk("R1", "wr_n", bus_wr_n, 1'b1);
        chk("R1", "done", done, 1'b0);
        chk("R1", "rd_data", rd_data, 16'h0);

        // sweep of area, width, length and wait code
        cfg_exp_cs_en = 1'b1;
        for (int area = 0; area < 3; area++)
            for (int w = 0; w < 2; w++)
                for (int l = 0; l < 2; l++)
                    for (int c = 0; c < 8; c++) begin
                        cfg_basic_wide = w[0]; cfg_exp_wide = w[0];
                        cfg_basic_long = l[0]; cfg_exp_long = l[0];
                        cfg_wait_code = 3'(c);
                        run_access(area, 16'h1234 + 16'(c * 2), 1'b0, 1'b1, 16'h0,
                                   tag_for(area, l[0]), 1'b0, 1'b0);
                    end

        // R6: disabled expansion select removes waits
        cfg_exp_cs_en = 1'b0; cfg_exp_long = 1'b1; cfg_wait_code = 3'd7; cfg_exp_wide = 1'b1;
        run_access(1, 16'h0400, 1'b0, 1'b1, 16'h0, "R6", 1'b0, 1'b0);
        run_access(2, 16'h0402, 1'b0, 1'b1, 16'h0, "R6", 1'b0, 1'b0);
        cfg_exp_cs_en = 1'b1;

        // R7: card mode widens only expansion area A
        cfg_card_mode = 1'b1; cfg_exp_wide = 1'b0; cfg_basic_wide = 1'b0;
        cfg_exp_long = 1'b0; cfg_basic_long = 1'b0;
        run_access(1, 16'h2000, 1'b0, 1'b1, 16'h0, "R7", 1'b0, 1'b0);
        run_access(2, 16'h2004, 1'b0, 1'b1, 16'h0, "R7", 1'b0, 1'b0);
        run_access(0, 16'h2008, 1'b0, 1'b1, 16'h0, "R7", 1'b0, 1'b0);
        cfg_card_mode = 1'b0;

        // R8 / R9 / R10: writes and byte accesses
        cfg_basic_long = 1'b1; cfg_exp_long = 1'b1; cfg_wait_code = 3'd2;
        run_access(0, 16'h3001, 1'b1, 1'b1, 16'hBEEF, "R8", 1'b0, 1'b0);
        run_access(2, 16'h3011, 1'b1, 1'b0, 16'hC3A7, "R9", 1'b0, 1'b0);
        cfg_basic_wide = 1'b1; cfg_exp_wide = 1'b1;
        run_access(0, 16'h3020, 1'b1, 1'b1, 16'h1357, "R9", 1'b0, 1'b0);
        run_access(1, 16'h3033, 1'b0, 1'b0, 16'h0, "R9", 1'b0, 1'b0);
        run_access(1, 16'h3041, 1'b1, 1'b1, 16'h2468, "R10", 1'b0, 1'b0);

        // R3: spare area code acts as basic
        cfg_basic_wide = 1'b0;
        run_access(3, 16'h3100, 1'b0, 1'b1, 16'h0, "R3", 1'b0, 1'b0);

        // R11: config changed mid-access, request poked while busy
        cfg_exp_wide = 1'b0; cfg_wait_code = 3'd5;
        run_access(2, 16'h4000, 1'b0, 1'b1, 16'h0, "R11", 1'b0, 1'b1);
        cfg_wait_code = 3'd7;
        run_access(2, 16'h4010, 1'b1, 1'b1, 16'hA55A, "R11", 1'b1, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule